// File: doc/BRIEF.md
# Huffman Fetch-Path Instruction Decompressor

This unit sits between a level-one cache that holds compressed code and the processor's fetch port. On every fetch it turns canonical Huffman codewords back into 32-bit instructions. Each codeword stands for one byte, and four decoded bytes form one instruction. The first byte decoded becomes the most significant byte. A software-built code table is written through a load port before use. The table holds the number of codewords of each length and the symbols in canonical order. A line table is written through the same port. It gives, for every block of four instructions, the compressed byte address where that block starts. Every block starts on a byte boundary, so a branch can begin decoding at any block.

A fetch of the instruction that directly follows the last one delivered continues from the current bit position. Any other fetch is non-sequential. It flushes the bit buffer, issues a restart with the block's byte address to the byte source, and decodes forward from the block start. Instructions in front of the target are decoded and dropped. While the unit works it raises `stall`, and a free-running counter totals the stall cycles, which is the decompression overhead.

The controller has three states. IDLE waits for a fetch. SEEK lasts one cycle and issues the restart. DECODE consumes one code bit per cycle and pulls a new byte whenever the buffer is empty. The transitions are:
- IDLE→DECODE on a sequential fetch.
- IDLE→SEEK on a non-sequential fetch.
- SEEK→DECODE always.
- DECODE→IDLE when the fourth byte of the target instruction is decoded.

Top module: `huff_fetch_decomp`

## Requirements
- R1: After reset, `stall`, `instr_valid`, `stream_ready` and `stream_restart` are low and `stall_count` is zero.
- R2: Canonical decoding works as follows. Codes of length L are consecutive values. The first code of length 1 is 0. The first code of length L+1 is (first code of L + count of L) shifted left by one. Symbols are indexed in ascending length, then ascending code. Bits are taken MSB first from each byte. Four symbols form the instruction, with the first symbol in bits 31:24.
- R3: A fetch whose address equals the previous delivered address plus one continues the bit stream and produces no restart.
- R4: A non-sequential fetch produces exactly one restart pulse. The restart address is the line-table entry of block `fetch_addr>>2`. Decoding starts at the block's first instruction, and the instructions before the target are discarded.
- R5: After the last instruction of a four-instruction block, the remaining bits of the current byte are dropped, so the next block starts at a byte boundary.
- R6: `stall` is high from the cycle after a fetch is accepted until the cycle in which `instr_valid` pulses. `instr_valid` lasts one cycle, with `stall` low.
- R7: `stall_count` grows by one for every cycle in which `stall` is high.
- R8: A byte is taken only in a cycle with both `stream_valid` and `stream_ready` high. `stream_ready` stays high until a byte arrives. Decoding is correct under arbitrary gaps in `stream_valid`.
- R9: `fetch_req` is ignored while `stall` is high. The result is the instruction from the accepted address.
- R10: The first fetch after reset is always non-sequential, including a fetch of address 0.
- R11: The load port writes by kind: 0 writes a symbol entry at `tbl_idx`, 1 writes the codeword count of length `tbl_idx`, and 2 writes a line-table entry. Counts clear on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Fetch request, accepted only while not stalled |
| fetch_addr | input | 8 | Uncompressed instruction index |
| stall | output | 1 | Decoder busy, instruction not yet assembled |
| instr_valid | output | 1 | One-cycle pulse with a decoded instruction |
| instr | output | 32 | Decoded instruction |
| stall_count | output | 32 | Total stall cycles since reset |
| stream_restart | output | 1 | Byte source must jump to `stream_addr` |
| stream_addr | output | 12 | Compressed byte address for a restart |
| stream_data | input | 8 | Compressed byte |
| stream_valid | input | 1 | Byte source has a byte |
| stream_ready | output | 1 | Decoder takes a byte this cycle |
| tbl_we | input | 1 | Table write strobe |
| tbl_kind | input | 2 | 0 symbol, 1 length count, 2 line table |
| tbl_idx | input | 8 | Table index |
| tbl_data | input | 12 | Table write data |

## Verification
The bench goes after the points where decoding must resume at exactly the right bit. The first such point is a sequential crossing of a block edge, where the padding bits must be dropped. A design that kept them would decode garbage from then on. The second is a jump into the middle of a block, where a design that skipped the discard step would deliver the block's first instruction instead of the target. The bench also checks these corner cases:
- A repeated fetch of the same address must count as non-sequential. A design that wrongly continued would return the following instruction.
- The first fetch after reset must restart.
- A fetch request during a stall must not retarget the decoder.
- Gaps in the byte stream must not lose or duplicate bytes.
- The stall counter must match the observed stall cycles exactly, so an off-by-one in the overhead accounting is visible.

// File: rtl/hfd_pkg.sv
package hfd_pkg;
    typedef enum logic [1:0] {
        TBL_SYM = 2'd0,
        TBL_LEN = 2'd1,
        TBL_LAT = 2'd2
    } tbl_kind_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SEEK   = 2'd1,
        S_DECODE = 2'd2
    } dstate_e;
endpackage

// File: rtl/hfd_tables.sv
module hfd_tables
    import hfd_pkg::*;
#(
    parameter int MAX_LEN   = 12,
    parameter int CA_W      = 12,
    parameter int LAT_AW    = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  tbl_kind_e                 kind_i,
    input  logic [7:0]                idx_i,
    input  logic [CA_W-1:0]           data_i,
    output logic [MAX_LEN:1][8:0]     cnt_o,
    input  logic [7:0]                sym_addr_i,
    output logic [7:0]                sym_o,
    input  logic [LAT_AW-1:0]         lat_addr_i,
    output logic [CA_W-1:0]           lat_o
);
    localparam int LAT_DEPTH = 1 << LAT_AW;

    logic [MAX_LEN:1][8:0] cnt_q;
    logic [7:0]            sym_mem [256];
    logic [CA_W-1:0]       lat_mem [LAT_DEPTH];

    // R11: per-length codeword counts, cleared on reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (we_i && kind_i == TBL_LEN) begin
            for (int l = 1; l <= MAX_LEN; l++) begin
                if (idx_i == 8'(l)) cnt_q[l] <= data_i[8:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (we_i && kind_i == TBL_SYM) sym_mem[idx_i] <= data_i[7:0];
    end

    always_ff @(posedge clk) begin
        if (we_i && kind_i == TBL_LAT && {1'b0, idx_i} < 9'(LAT_DEPTH))
            lat_mem[idx_i[LAT_AW-1:0]] <= data_i;
    end

    assign cnt_o = cnt_q;
    assign sym_o = sym_mem[sym_addr_i];
    assign lat_o = lat_mem[lat_addr_i];
endmodule

// File: rtl/hfd_canon.sv
module hfd_canon #(
    parameter int MAX_LEN = 12,
    parameter int CW      = MAX_LEN + 1
) (
    input  logic [MAX_LEN:1][8:0]    cnt_i,
    output logic [MAX_LEN:1][CW-1:0] first_o,
    output logic [MAX_LEN:1][7:0]    base_o
);
    // R2: first code and symbol base per length, derived from counts
    always_comb begin
        logic [CW-1:0] f;
        logic [7:0]    b;
        f = '0;
        b = '0;
        for (int l = 1; l <= MAX_LEN; l++) begin
            first_o[l] = f;
            base_o[l]  = b;
            f = CW'((f + CW'(cnt_i[l])) << 1);
            b = 8'(b + cnt_i[l]);
        end
    end
endmodule

// File: rtl/huff_fetch_decomp.sv
module huff_fetch_decomp
    import hfd_pkg::*;
#(
    parameter int IA_W     = 8,
    parameter int BLK_LOG2 = 2,
    parameter int CA_W     = 12,
    parameter int MAX_LEN  = 12,
    parameter int INSTR_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_req,
    input  logic [IA_W-1:0]    fetch_addr,
    output logic               stall,
    output logic               instr_valid,
    output logic [INSTR_W-1:0] instr,
    output logic [31:0]        stall_count,
    output logic               stream_restart,
    output logic [CA_W-1:0]    stream_addr,
    input  logic [7:0]         stream_data,
    input  logic               stream_valid,
    output logic               stream_ready,
    input  logic               tbl_we,
    input  logic [1:0]         tbl_kind,
    input  logic [7:0]         tbl_idx,
    input  logic [CA_W-1:0]    tbl_data
);
    localparam int LAT_AW = IA_W - BLK_LOG2;
    localparam int LW     = $clog2(MAX_LEN + 1);
    localparam int CW     = MAX_LEN + 1;
    localparam int SPI    = INSTR_W / 8;
    localparam int SCW    = $clog2(SPI);

    dstate_e state_q, state_d;

    logic [7:0]         bitbuf_q;
    logic [3:0]         bitcnt_q;
    logic [MAX_LEN-2:0] code_q;
    logic [LW-1:0]      clen_q;
    logic [INSTR_W-9:0] sr_q;
    logic [SCW-1:0]     symcnt_q;
    logic [IA_W-1:0]    cur_q, tgt_q, nxt_q;
    logic               seq_ok_q;

    logic [MAX_LEN:1][8:0]    cnt_vec;
    logic [MAX_LEN:1][CW-1:0] first_vec;
    logic [MAX_LEN:1][7:0]    base_vec;
    logic [7:0]               sym_addr, sym_rd;
    logic [CA_W-1:0]          lat_rd;

    hfd_tables #(.MAX_LEN(MAX_LEN), .CA_W(CA_W), .LAT_AW(LAT_AW)) u_tables (
        .clk(clk), .rst_n(rst_n), .we_i(tbl_we), .kind_i(tbl_kind_e'(tbl_kind)),
        .idx_i(tbl_idx), .data_i(tbl_data), .cnt_o(cnt_vec),
        .sym_addr_i(sym_addr), .sym_o(sym_rd),
        .lat_addr_i(tgt_q[IA_W-1:BLK_LOG2]), .lat_o(lat_rd)
    );

    hfd_canon #(.MAX_LEN(MAX_LEN), .CW(CW)) u_canon (
        .cnt_i(cnt_vec), .first_o(first_vec), .base_o(base_vec)
    );

    // one code bit per cycle: extend the code and test it against its length
    logic [MAX_LEN-1:0] code_nxt;
    logic [LW-1:0]      clen_nxt;
    logic [CW-1:0]      code_ext, diff;
    logic               hit, have_bit, last_sym, seq_hit, done;

    always_comb begin
        code_nxt = {code_q, bitbuf_q[7]};
        clen_nxt = clen_q + LW'(1);
        code_ext = CW'(code_nxt);
        diff     = code_ext - first_vec[clen_nxt];
        hit      = (code_ext >= first_vec[clen_nxt]) && (diff < CW'(cnt_vec[clen_nxt]));
        sym_addr = base_vec[clen_nxt] + diff[7:0];
        have_bit = bitcnt_q != 4'd0;
        last_sym = symcnt_q == SCW'(SPI - 1);
        seq_hit  = seq_ok_q && (fetch_addr == nxt_q);
        done     = (state_q == S_DECODE) && have_bit && hit && last_sym && (cur_q == tgt_q);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (fetch_req) state_d = seq_hit ? S_DECODE : S_SEEK;
            S_SEEK:   state_d = S_DECODE;
            S_DECODE: if (done) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitbuf_q    <= '0;
            bitcnt_q    <= '0;
            code_q      <= '0;
            clen_q      <= '0;
            sr_q        <= '0;
            symcnt_q    <= '0;
            cur_q       <= '0;
            tgt_q       <= '0;
            nxt_q       <= '0;
            seq_ok_q    <= 1'b0;
            instr       <= '0;
            instr_valid <= 1'b0;
            stall_count <= '0;
        end else begin
            instr_valid <= 1'b0;
            if (stall) stall_count <= stall_count + 32'd1;
            unique case (state_q)
                S_IDLE: begin
                    if (fetch_req) begin
                        tgt_q    <= fetch_addr;
                        code_q   <= '0;
                        clen_q   <= '0;
                        symcnt_q <= '0;
                        if (seq_hit) begin
                            cur_q <= fetch_addr;
                        end else begin
                            cur_q    <= {fetch_addr[IA_W-1:BLK_LOG2], BLK_LOG2'(0)};
                            bitcnt_q <= '0;
                        end
                    end
                end
                S_SEEK: begin
                end
                S_DECODE: begin
                    if (!have_bit) begin
                        if (stream_valid) begin
                            bitbuf_q <= stream_data;
                            bitcnt_q <= 4'd8;
                        end
                    end else begin
                        bitbuf_q <= {bitbuf_q[6:0], 1'b0};
                        bitcnt_q <= bitcnt_q - 4'd1;
                        if (hit) begin
                            code_q   <= '0;
                            clen_q   <= '0;
                            sr_q     <= {sr_q[INSTR_W-17:0], sym_rd};
                            symcnt_q <= symcnt_q + SCW'(1);
                            if (last_sym) begin
                                cur_q <= cur_q + IA_W'(1);
                                if (&cur_q[BLK_LOG2-1:0]) bitcnt_q <= '0;
                                if (cur_q == tgt_q) begin
                                    instr       <= {sr_q, sym_rd};
                                    instr_valid <= 1'b1;
                                    nxt_q       <= cur_q + IA_W'(1);
                                    seq_ok_q    <= 1'b1;
                                end
                            end
                        end else if (clen_nxt == LW'(MAX_LEN)) begin
                            code_q <= '0;
                            clen_q <= '0;
                        end else begin
                            code_q <= code_nxt[MAX_LEN-2:0];
                            clen_q <= clen_nxt;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        stall          = state_q != S_IDLE;
        stream_restart = state_q == S_SEEK;
        stream_ready   = (state_q == S_DECODE) && !have_bit;
        stream_addr    = lat_rd;
    end

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> !instr_valid);
    p_stall_ends_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> instr_valid);
    p_restart_after_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stream_restart |-> $past(fetch_req));
    p_stall_counted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> stall_count == $past(stall_count) + 32'd1);
    p_ready_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_ready && !stream_valid) |=> stream_ready);
endmodule

// File: tb/test_huff_fetch_decomp.sv
module test_huff_fetch_decomp;
    localparam int NI = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [7:0]  fetch_addr = '0;
    logic        stall, instr_valid, stream_restart, stream_ready;
    logic [31:0] instr, stall_count;
    logic [11:0] stream_addr;
    logic [7:0]  stream_data;
    logic        stream_valid = 1'b1;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_kind = '0;
    logic [7:0]  tbl_idx = '0;
    logic [11:0] tbl_data = '0;

    always #2 clk = ~clk;

    huff_fetch_decomp i_huff_fetch_decomp (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .stall(stall), .instr_valid(instr_valid), .instr(instr), .stall_count(stall_count),
        .stream_restart(stream_restart), .stream_addr(stream_addr),
        .stream_data(stream_data), .stream_valid(stream_valid), .stream_ready(stream_ready),
        .tbl_we(tbl_we), .tbl_kind(tbl_kind), .tbl_idx(tbl_idx), .tbl_data(tbl_data)
    );

    int          nchk = 0, nfail = 0, restarts = 0;
    logic [11:0] last_rs_addr = '0;
    logic [7:0]  comp [0:511];
    logic [11:0] latv [0:15];
    logic [31:0] prog [0:NI-1];
    logic [11:0] code_of [0:255];
    int          len_of [0:255];
    logic [7:0]  sym_list [0:255];
    int          cnt [1:12];
    logic [9:0]  sptr = '0;
    bit          gaps = 1'b0;

    // byte source model
    assign stream_data = comp[sptr];
    always @(posedge clk) begin
        if (stream_restart) begin
            sptr <= stream_addr[9:0];
            restarts <= restarts + 1;
            last_rs_addr <= stream_addr;
        end else if (stream_valid && stream_ready) begin
            sptr <= sptr + 10'd1;
        end
    end
    always @(negedge clk) stream_valid <= gaps ? (($urandom % 3) != 0) : 1'b1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] k, input int idx, input int d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_kind = k; tbl_idx = 8'(idx); tbl_data = 12'(d);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic load_all();
        for (int l = 1; l <= 12; l++) load(2'd1, l, cnt[l]);   // R11 kind 1
        for (int i = 0; i < 256; i++) load(2'd0, i, sym_list[i]); // R11 kind 0
        for (int b = 0; b < 16; b++) load(2'd2, b, latv[b]);   // R11 kind 2
    endtask

    task automatic do_fetch(input int a, input bit exp_rs, input bit poke);
        int r0, cyc, stalled;
        logic [31:0] sc0;
        r0 = restarts; cyc = 0; stalled = 0;
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = 8'(a); sc0 = stall_count;
        @(negedge clk);
        fetch_req = 1'b0;
        chk(stall === 1'b1, "R6 stall after accept", 32'(stall), 1);
        if (poke) begin fetch_req = 1'b1; fetch_addr = 8'(a ^ 5); end   // R9
        while (instr_valid !== 1'b1 && cyc < 3000) begin
            if (stall) stalled++;
            cyc++;
            @(negedge clk);
            fetch_req = 1'b0;
        end
        chk(cyc < 3000, "R6 instruction delivered", 32'(cyc), 0);
        chk(instr === prog[a], poke ? "R9 fetch during stall ignored" : "R2 R8 decoded instruction",
            instr, prog[a]);
        chk(restarts - r0 == int'(exp_rs), exp_rs ? "R4 R10 restart issued" : "R3 no restart",
            32'(restarts - r0), 32'(exp_rs));
        if (exp_rs) chk(last_rs_addr === latv[a >> 2], "R4 restart address", 32'(last_rs_addr), 32'(latv[a >> 2]));
        chk(stall === 1'b0, "R6 stall low with valid", 32'(stall), 0);
        chk(stall_count - sc0 == 32'(stalled), "R7 stall count", stall_count - sc0, 32'(stalled));
        @(negedge clk);
        chk(instr_valid === 1'b0, "R6 valid single pulse", 32'(instr_valid), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(stall === 1'b0 && instr_valid === 1'b0 && stream_ready === 1'b0 && stream_restart === 1'b0,
            "R1 reset outputs", {stall, instr_valid, stream_ready, stream_restart}, 0);
        chk(stall_count === 32'd0, "R1 stall count reset", stall_count, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int dummy, bp, idx, prev, a;
        logic [11:0] c;
        dummy = $urandom(32'd4242);
        // code table: counts per length, symbols in a permuted order
        for (int l = 1; l <= 12; l++) cnt[l] = 0;
        cnt[3] = 2; cnt[5] = 8; cnt[7] = 16; cnt[9] = 64; cnt[10] = 166;
        for (int i = 0; i < 256; i++) sym_list[i] = 8'((i * 167 + 13) % 256);
        idx = 0; c = '0;
        for (int l = 1; l <= 12; l++) begin
            for (int k = 0; k < cnt[l]; k++) begin
                code_of[sym_list[idx]] = c; len_of[sym_list[idx]] = l;
                c++; idx++;
            end
            c = c << 1;
        end
        // program: directed shortest/longest codes, then random words
        prog[0] = {sym_list[0], sym_list[1], sym_list[0], sym_list[1]};
        prog[1] = {sym_list[255], sym_list[254], sym_list[255], sym_list[90]};
        for (int i = 2; i < NI; i++) prog[i] = $urandom;
        // encode with block-aligned starts
        for (int i = 0; i < 512; i++) comp[i] = '0;
        bp = 0;
        for (int i = 0; i < NI; i++) begin
            if (i % 4 == 0) begin bp = (bp + 7) / 8 * 8; latv[i / 4] = 12'(bp / 8); end
            for (int s = 3; s >= 0; s--) begin
                logic [7:0] sy;
                sy = prog[i][8*s +: 8];
                for (int b = len_of[sy] - 1; b >= 0; b--) begin
                    comp[bp / 8][7 - bp % 8] = code_of[sy][b];
                    bp++;
                end
            end
        end

        do_reset();
        load_all();
        do_fetch(0, 1'b1, 1'b0);                    // R10 first fetch restarts
        for (int i = 1; i < 8; i++) do_fetch(i, 1'b0, 1'b0); // R3, R5 block edge at 4
        do_fetch(10, 1'b1, 1'b0);                   // R4 mid-block target
        do_fetch(11, 1'b0, 1'b1);                   // R9 poke during stall
        do_fetch(11, 1'b1, 1'b0);                   // repeat address is non-sequential
        gaps = 1'b1;                                // R8 byte gaps
        do_fetch(12, 1'b0, 1'b0);                   // R5 sequential into new block
        prev = 12;
        for (int n = 0; n < 200; n++) begin
            if (prev < NI - 1 && ($urandom % 2) == 1) a = prev + 1;
            else a = int'($urandom % NI);
            do_fetch(a, a != prev + 1, 1'b0);
            prev = a;
        end
        do_reset();
        load_all();
        do_fetch(prev + 1 < NI ? prev + 1 : 0, 1'b1, 1'b0); // R10 after reset
        do_fetch(0, 1'b1, 1'b0);                    // R10 address 0
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule